// File: doc/BRIEF.md
# Shared-Interrupt State Bitmaps with Security Masking

This block keeps three one-bit-per-interrupt state vectors (enable, pending, active) for the shared interrupt range of an interrupt distributor. Interrupts 0 to 31 are internal to each processor and have no storage here. Software reaches the vectors through 32-bit register windows. Each vector has a set-style window, where a 1 sets a bit, and a clear-style window, where a 1 clears a bit. Alongside the vectors the block stores, per interrupt, a group bit, an edge/level trigger bit and a 2-bit non-secure access grade. Together with a one-way security-disable control bit, these decide which bits a given requester may see or change.

Each shared interrupt also has an input line. The line is sampled every cycle. A rising edge latches the pending bit of an edge-type interrupt. The live level of a level-type interrupt is folded into every pending read. The register bus takes one request per cycle. Read data comes back registered in the following cycle. Prioritisation, routing and signalling toward processors belong to the neighbouring blocks.

Top module: `shared_irq_bitmaps`

## Requirements
- R1: A write to a set-style window (enable, pending, active) ORs the masked write data into the addressed 32-bit word of that vector. Data bits that are 0 change nothing.
- R2: A write to a clear-style window clears every bit of the addressed word where the masked write data is 1.
- R3: Word index 0 (interrupts 0 to 31) and every word index at or above NUM_IRQ/32 read as zero in all interrupt windows, and writes to them are ignored.
- R4: The access mask is all ones when the request is secure or the security-disable bit is set. Otherwise the mask is the group bit of each interrupt (1 = non-secure group), ORed with the grade mask named for the window.
- R5: The grade field of interrupt 16k+j sits at bits [2j+1:2j] of word k of the grade window. A grade of 1, 2 or 3 lets a non-secure request read the set-pending window and set pending bits of a group-0 interrupt.
- R6: A grade of 2 or 3 lets a non-secure request read the clear-pending window and clear pending bits of a group-0 interrupt. The same grade lets it read the active vector through either active window.
- R7: Non-secure writes to the set-active and clear-active windows are masked by the group bits only, whatever the grade.
- R8: A pending read returns the pending latch ORed with (sampled line level AND NOT edge-type). The live level of a level-type interrupt cannot be cleared by a clear-pending write.
- R9: A 0-to-1 change of a line sets the pending latch only for an interrupt whose trigger bit is 1 (edge). A line held high does not set it again after a clear. An edge that arrives in the same cycle as a clear of that bit leaves the bit set.
- R10: The group window and the grade window are read-as-zero and write-ignored for a non-secure request while security-disable is clear. The grade window is also read-as-zero and write-ignored while security-disable is set. A write to the trigger window uses the base access mask of R4.
- R11: Bit 0 of control word 0 is security-disable. Only a secure write of 1 sets it. It then stays 1 until reset, and it reads back for any requester.
- R12: Address bits [9:6] select the window: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 set-active, 5 clear-active, 6 group, 7 trigger (1 = edge), 8 grade, 9 control. Bits [5:0] give the word index. Other windows read zero. Read data appears on the cycle after the read request and holds until the next read. All state is zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Requester is secure |
| req_addr | input | 10 | Window select [9:6], word index [5:0] |
| req_wdata | input | 32 | Write data |
| irq_line_i | input | NUM_IRQ-32 | Input lines of interrupts 32 upward, bit i is interrupt 32+i |
| rsp_rdata | output | 32 | Registered read data |

## Verification
Several properties are checked by the assertions on every cycle:
- a vector with no set or clear request holds its value;
- a set request always wins over a clear in the same cycle;
- a line cannot report two rises in a row;
- security-disable never falls back;
- non-secure group writes leave the group bits alone;
- word 0 always reads zero;
- read data holds between reads.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- the graded masks, where grade 1 differs from grade 2 only for pending clears and active reads;
- the merge of the live level into pending reads;
- the change of every mask once security-disable is set;
- the long mixed random sequence of reads, writes and line toggles.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int WORD_W       = 32;
  localparam int IDX_W        = 6;
  localparam int WIN_W        = 4;
  localparam int ADDR_W       = WIN_W + IDX_W;
  localparam int FIRST_SHARED = 32;
  localparam int GRADE_W      = 2;
  localparam int GRADES_PER_W = WORD_W / GRADE_W;

  typedef enum logic [WIN_W-1:0] {
    WIN_EN_SET = 4'd0,
    WIN_EN_CLR = 4'd1,
    WIN_PD_SET = 4'd2,
    WIN_PD_CLR = 4'd3,
    WIN_AC_SET = 4'd4,
    WIN_AC_CLR = 4'd5,
    WIN_GROUP  = 4'd6,
    WIN_TRIG   = 4'd7,
    WIN_GRADE  = 4'd8,
    WIN_CTRL   = 4'd9,
    WIN_R10    = 4'd10,
    WIN_R11    = 4'd11,
    WIN_R12    = 4'd12,
    WIN_R13    = 4'd13,
    WIN_R14    = 4'd14,
    WIN_R15    = 4'd15
  } win_e;

  typedef struct packed {
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] ge1;
    logic [WORD_W-1:0] ge2;
  } acc_mask_t;
endpackage

// File: rtl/sbm_access_mask.sv
module sbm_access_mask
  import sbm_pkg::*;
(
  input  logic                      ns_restrict,
  input  logic [WORD_W-1:0]         group_i,
  input  logic [GRADE_W*WORD_W-1:0] grade_i,
  output acc_mask_t                 mask_o
);
  logic [WORD_W-1:0] at_least_1;
  logic [WORD_W-1:0] at_least_2;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign at_least_1[b] = grade_i[GRADE_W*b] | grade_i[GRADE_W*b+1];
    assign at_least_2[b] = grade_i[GRADE_W*b+1];
  end

  always_comb begin
    if (ns_restrict) begin
      mask_o.base = group_i;
      mask_o.ge1  = group_i | at_least_1;
      mask_o.ge2  = group_i | at_least_2;
    end else begin
      mask_o.base = '1;
      mask_o.ge1  = '1;
      mask_o.ge2  = '1;
    end
  end
endmodule

// File: rtl/sbm_line_edge.sv
module sbm_line_edge #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] level_q;
  logic             level_en;

  assign level_en = (line_i != level_q);
  assign rise_o   = line_i & ~level_q;
  assign level_o  = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else if (level_en) level_q <= line_i;
  end

  AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R9
endmodule

// File: rtl/sbm_bitmap.sv
module sbm_bitmap #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] bits_o
);
  logic [WIDTH-1:0] bits_q;
  logic [WIDTH-1:0] bits_d;
  logic             upd_en;

  assign upd_en = |(set_i | clr_i);

  always_comb begin
    bits_d = (bits_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else if (upd_en) bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i | clr_i) == '0) |=> $stable(bits_o)); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((bits_o & $past(set_i)) == $past(set_i))); // R9
endmodule

// File: rtl/shared_irq_bitmaps.sv
module shared_irq_bitmaps
  import sbm_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_secure,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [NUM_IRQ-33:0]     irq_line_i,
  output logic [WORD_W-1:0]       rsp_rdata
);
  localparam int NUM_SPI     = NUM_IRQ - FIRST_SHARED;
  localparam int NUM_WORDS   = NUM_IRQ / WORD_W;
  localparam int SPI_WORDS   = NUM_WORDS - 1;
  localparam int GRADE_FIRST = FIRST_SHARED / GRADES_PER_W;
  localparam int GRADE_WORDS = NUM_SPI / GRADES_PER_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  win_e             win;
  logic [IDX_W-1:0] idx;
  logic             rd_req, wr_req, ns_restrict;

  logic [NUM_SPI-1:0]         grp_q, grp_d, trig_q, trig_d;
  logic [GRADE_W*NUM_SPI-1:0] grade_q, grade_d;
  logic                       ds_q, ds_d;
  logic [WORD_W-1:0]          rdata_q, rdata_d;
  logic                       grp_we, trig_we, grade_we, ds_we, rdata_we;

  logic [NUM_SPI-1:0] en_bits, pend_bits, act_bits;
  logic [NUM_SPI-1:0] line_lvl, line_rise, pend_view;
  logic [NUM_SPI-1:0] spread, zero_vec;
  logic [NUM_SPI-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;

  acc_mask_t         word_mask [SPI_WORDS];
  acc_mask_t         sel_mask;
  logic [WORD_W-1:0] sel_en, sel_pend, sel_act, sel_grp, sel_trig, sel_grade;
  logic [WORD_W-1:0] wr_masked;

  assign win         = win_e'(req_addr[ADDR_W-1:IDX_W]);
  assign idx         = req_addr[IDX_W-1:0];
  assign rd_req      = req_valid & ~req_write;
  assign wr_req      = req_valid & req_write;
  assign ns_restrict = ~req_secure & ~ds_q;
  assign zero_vec    = '0;

  for (genvar w = 0; w < SPI_WORDS; w++) begin : g_mask
    sbm_access_mask u_mask (
      .ns_restrict (ns_restrict),
      .group_i     (grp_q[w*WORD_W +: WORD_W]),
      .grade_i     (grade_q[w*GRADE_W*WORD_W +: GRADE_W*WORD_W]),
      .mask_o      (word_mask[w])
    );
  end

  sbm_line_edge #(.WIDTH(NUM_SPI)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .line_i  (irq_line_i),
    .level_o (line_lvl),
    .rise_o  (line_rise)
  );

  assign pend_view = pend_bits | (line_lvl & ~trig_q);

  // selection of the addressed word (index 0 and out-of-range select nothing)
  always_comb begin
    sel_mask  = '0;
    sel_en    = '0;
    sel_pend  = '0;
    sel_act   = '0;
    sel_grp   = '0;
    sel_trig  = '0;
    sel_grade = '0;
    for (int w = 0; w < SPI_WORDS; w++) begin
      if (int'(idx) == w + 1) begin
        sel_mask = word_mask[w];
        sel_en   = en_bits[w*WORD_W +: WORD_W];
        sel_pend = pend_view[w*WORD_W +: WORD_W];
        sel_act  = act_bits[w*WORD_W +: WORD_W];
        sel_grp  = grp_q[w*WORD_W +: WORD_W];
        sel_trig = trig_q[w*WORD_W +: WORD_W];
      end
    end
    for (int k = 0; k < GRADE_WORDS; k++) begin
      if (int'(idx) == k + GRADE_FIRST) sel_grade = grade_q[k*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    case (win)
      WIN_PD_SET: wr_masked = req_wdata & sel_mask.ge1;
      WIN_PD_CLR: wr_masked = req_wdata & sel_mask.ge2;
      default:    wr_masked = req_wdata & sel_mask.base;
    endcase
    spread = '0;
    for (int w = 0; w < SPI_WORDS; w++) begin
      if (int'(idx) == w + 1) spread[w*WORD_W +: WORD_W] = wr_masked;
    end
  end

  assign en_set = (wr_req && win == WIN_EN_SET) ? spread : zero_vec;
  assign en_clr = (wr_req && win == WIN_EN_CLR) ? spread : zero_vec;
  assign pd_set = ((wr_req && win == WIN_PD_SET) ? spread : zero_vec) | (line_rise & trig_q);
  assign pd_clr = (wr_req && win == WIN_PD_CLR) ? spread : zero_vec;
  assign ac_set = (wr_req && win == WIN_AC_SET) ? spread : zero_vec;
  assign ac_clr = (wr_req && win == WIN_AC_CLR) ? spread : zero_vec;

  sbm_bitmap #(.WIDTH(NUM_SPI)) u_enable (
    .clk (clk), .rst_n (rst_n_int), .set_i (en_set), .clr_i (en_clr), .bits_o (en_bits));
  sbm_bitmap #(.WIDTH(NUM_SPI)) u_pending (
    .clk (clk), .rst_n (rst_n_int), .set_i (pd_set), .clr_i (pd_clr), .bits_o (pend_bits));
  sbm_bitmap #(.WIDTH(NUM_SPI)) u_active (
    .clk (clk), .rst_n (rst_n_int), .set_i (ac_set), .clr_i (ac_clr), .bits_o (act_bits));

  // configuration next state
  assign grp_we   = wr_req && (win == WIN_GROUP) && !ns_restrict;
  assign trig_we  = wr_req && (win == WIN_TRIG);
  assign grade_we = wr_req && (win == WIN_GRADE) && req_secure && !ds_q;
  assign ds_we    = wr_req && (win == WIN_CTRL) && (idx == '0) && req_secure &&
                    !ds_q && req_wdata[0];

  always_comb begin
    grp_d   = grp_q;
    trig_d  = trig_q;
    grade_d = grade_q;
    for (int w = 0; w < SPI_WORDS; w++) begin
      if (int'(idx) == w + 1) begin
        grp_d[w*WORD_W +: WORD_W]  = req_wdata;
        trig_d[w*WORD_W +: WORD_W] = (trig_q[w*WORD_W +: WORD_W] & ~word_mask[w].base) |
                                     (req_wdata & word_mask[w].base);
      end
    end
    for (int k = 0; k < GRADE_WORDS; k++) begin
      if (int'(idx) == k + GRADE_FIRST) grade_d[k*WORD_W +: WORD_W] = req_wdata;
    end
    ds_d = 1'b1;
  end

  // read data next state
  assign rdata_we = rd_req;
  always_comb begin
    case (win)
      WIN_EN_SET, WIN_EN_CLR: rdata_d = sel_en & sel_mask.base;
      WIN_PD_SET:             rdata_d = sel_pend & sel_mask.ge1;
      WIN_PD_CLR:             rdata_d = sel_pend & sel_mask.ge2;
      WIN_AC_SET, WIN_AC_CLR: rdata_d = sel_act & sel_mask.ge2;
      WIN_GROUP:              rdata_d = ns_restrict ? '0 : sel_grp;
      WIN_TRIG:               rdata_d = sel_trig & sel_mask.base;
      WIN_GRADE:              rdata_d = (req_secure && !ds_q) ? sel_grade : '0;
      WIN_CTRL:               rdata_d = (idx == '0) ? {{(WORD_W-1){1'b0}}, ds_q} : '0;
      default:                rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      grp_q   <= '0;
      trig_q  <= '0;
      grade_q <= '0;
      ds_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (grp_we)   grp_q   <= grp_d;
      if (trig_we)  trig_q  <= trig_d;
      if (grade_we) grade_q <= grade_d;
      if (ds_we)    ds_q    <= ds_d;
      if (rdata_we) rdata_q <= rdata_d;
    end
  end

  assign rsp_rdata = rdata_q;

  AST_LOW_WORD_RAZ: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_req && idx == '0 && win != WIN_CTRL) |=> (rsp_rdata == '0)); // R3
  AST_DISABLE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n_int)
    ds_q |=> ds_q); // R11
  AST_NS_GROUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_req && win == WIN_GROUP && !req_secure && !ds_q) |=> $stable(grp_q)); // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rd_req |=> $stable(rsp_rdata)); // R12
endmodule

// File: tb/shared_irq_bitmaps_tb_top.sv
module shared_irq_bitmaps_tb_top;
  localparam int N = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [N-33:0] irq_line = '0;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R12";
  bit running = 0;

  always #2 clk = ~clk;

  shared_irq_bitmaps #(.NUM_IRQ(N)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_secure (req_secure), .req_addr (req_addr), .req_wdata (req_wdata),
    .irq_line_i (irq_line), .rsp_rdata (rsp_rdata));

  // ---------------- reference model ----------------
  bit m_en[N], m_pd[N], m_ac[N], m_gp[N], m_tg[N], m_ln[N];
  int m_gr[N];
  bit m_ds;
  logic [31:0] exp_rd;

  function automatic bit in_range(int irq);
    return irq >= 32 && irq < N;
  endfunction

  function automatic bit may(int kind, int irq, bit sec);
    return m_ds || sec || m_gp[irq] || (kind == 1 && m_gr[irq] >= 1) ||
           (kind == 2 && m_gr[irq] >= 2);
  endfunction

  function automatic logic [31:0] m_read(int win, int idx, bit sec);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int irq = idx * 32 + b;
      if (in_range(irq)) begin
        case (win)
          0, 1: r[b] = may(0, irq, sec) & m_en[irq];
          2:    r[b] = may(1, irq, sec) & (m_pd[irq] | (m_ln[irq] & !m_tg[irq]));
          3:    r[b] = may(2, irq, sec) & (m_pd[irq] | (m_ln[irq] & !m_tg[irq]));
          4, 5: r[b] = may(2, irq, sec) & m_ac[irq];
          6:    r[b] = (sec || m_ds) & m_gp[irq];
          7:    r[b] = may(0, irq, sec) & m_tg[irq];
          default: ;
        endcase
      end
    end
    if (win == 8 && sec && !m_ds)
      for (int j = 0; j < 16; j++) begin
        int irq = idx * 16 + j;
        if (in_range(irq)) r[2*j +: 2] = 2'(m_gr[irq]);
      end
    if (win == 9 && idx == 0) r[0] = m_ds;
    return r;
  endfunction

  task automatic m_write(int win, int idx, bit sec, logic [31:0] d);
    for (int b = 0; b < 32; b++) begin
      int irq = idx * 32 + b;
      if (in_range(irq)) begin
        case (win)
          0: if (d[b] && may(0, irq, sec)) m_en[irq] = 1;
          1: if (d[b] && may(0, irq, sec)) m_en[irq] = 0;
          2: if (d[b] && may(1, irq, sec)) m_pd[irq] = 1;
          3: if (d[b] && may(2, irq, sec)) m_pd[irq] = 0;
          4: if (d[b] && may(0, irq, sec)) m_ac[irq] = 1;
          5: if (d[b] && may(0, irq, sec)) m_ac[irq] = 0;
          6: if (sec || m_ds) m_gp[irq] = d[b];
          7: if (may(0, irq, sec)) m_tg[irq] = d[b];
          default: ;
        endcase
      end
    end
    if (win == 8 && sec && !m_ds)
      for (int j = 0; j < 16; j++) begin
        int irq = idx * 16 + j;
        if (in_range(irq)) m_gr[irq] = int'(d[2*j +: 2]);
      end
    if (win == 9 && idx == 0 && sec && !m_ds && d[0]) m_ds = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_en[i] = 0; m_pd[i] = 0; m_ac[i] = 0; m_gp[i] = 0; m_tg[i] = 0; m_ln[i] = 0; m_gr[i] = 0;
      end
      m_ds = 0;
      exp_rd = '0;
    end else begin
      bit rs[N];
      if (req_valid && !req_write)
        exp_rd = m_read(int'(req_addr[9:6]), int'(req_addr[5:0]), req_secure);
      for (int i = 32; i < N; i++) rs[i] = irq_line[i-32] && !m_ln[i] && m_tg[i];
      if (req_valid && req_write)
        m_write(int'(req_addr[9:6]), int'(req_addr[5:0]), req_secure, req_wdata);
      for (int i = 32; i < N; i++) begin
        if (rs[i]) m_pd[i] = 1;
        m_ln[i] = irq_line[i-32];
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (rsp_rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s: model compare rdata actual %h expected %h", cur_req, rsp_rdata, exp_rd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R12: watchdog cycles actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(int win, int idx, bit wr, bit sec, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_secure = sec;
    req_addr = {4'(win), 6'(idx)}; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic chk(int win, int idx, bit sec, logic [31:0] e, string tag);
    cur_req = tag;
    op(win, idx, 0, sec, '0);
    checks++;
    if (rsp_rdata !== e) begin
      fails++;
      $display("FAIL %s: rdata actual %h expected %h", tag, rsp_rdata, e);
    end
  endtask

  task automatic line(int irq, bit v);
    @(negedge clk);
    irq_line[irq-32] = v;
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    running = 1;
    // R12 reset state
    chk(0, 1, 1, 32'h0, "R12");
    chk(7, 2, 1, 32'h0, "R12");
    // R1 set, zero bits ignored
    op(0, 1, 1, 1, 32'hA5A5_0F0F);
    op(0, 1, 1, 1, 32'h0000_F000);
    chk(0, 1, 1, 32'hA5A5_FF0F, "R1");
    op(0, 1, 1, 1, 32'h0);
    chk(1, 1, 1, 32'hA5A5_FF0F, "R1");
    // R2 clear
    op(1, 1, 1, 1, 32'h0F00_0F01);
    chk(0, 1, 1, 32'hA0A5_F00E, "R2");
    // R3 out of range
    op(0, 0, 1, 1, 32'hFFFF_FFFF);
    chk(0, 0, 1, 32'h0, "R3");
    op(0, 3, 1, 1, 32'hFFFF_FFFF);
    chk(0, 3, 1, 32'h0, "R3");
    // group setup, R10 group read gating
    op(6, 1, 1, 1, 32'hFFFF_0000);
    chk(6, 1, 0, 32'h0, "R10");
    chk(6, 1, 1, 32'hFFFF_0000, "R10");
    // R4 non-secure masked by group
    op(1, 1, 1, 0, 32'hFFFF_FFFF);
    chk(0, 1, 0, 32'h0, "R4");
    chk(0, 1, 1, 32'h0000_F00E, "R4");
    // grade setup: irq 32+j has grade j%4
    op(8, 2, 1, 1, 32'hE4E4_E4E4);
    chk(8, 2, 0, 32'h0, "R10");
    chk(8, 2, 1, 32'hE4E4_E4E4, "R5");
    // R5 set-pending with grade >= 1
    op(2, 1, 1, 0, 32'hFFFF_FFFF);
    chk(2, 1, 1, 32'hFFFF_EEEE, "R5");
    chk(2, 1, 0, 32'hFFFF_EEEE, "R5");
    chk(3, 1, 0, 32'hFFFF_CCCC, "R6");
    // R6 clear-pending with grade >= 2
    op(3, 1, 1, 0, 32'hFFFF_FFFF);
    chk(2, 1, 1, 32'h0000_2222, "R6");
    // R7 active writes group-only, R6 active read grade >= 2
    op(4, 1, 1, 0, 32'hFFFF_FFFF);
    chk(4, 1, 1, 32'hFFFF_0000, "R7");
    op(4, 1, 1, 1, 32'h0000_000F);
    chk(5, 1, 0, 32'hFFFF_000C, "R6");
    op(5, 1, 1, 0, 32'hFFFF_FFFF);
    chk(4, 1, 1, 32'h0000_000F, "R7");
    // R8 / R9 lines
    op(7, 1, 1, 1, 32'h0000_00FF);
    op(3, 1, 1, 1, 32'hFFFF_FFFF);
    @(negedge clk); irq_line[0] = 1; irq_line[8] = 1;
    chk(2, 1, 1, 32'h0000_0101, "R9");
    @(negedge clk); irq_line[0] = 0; irq_line[8] = 0;
    chk(2, 1, 1, 32'h0000_0001, "R8");
    line(40, 1);
    op(3, 1, 1, 1, 32'h0000_0101);
    chk(2, 1, 1, 32'h0000_0100, "R8");
    line(33, 1);
    chk(2, 1, 1, 32'h0000_0102, "R9");
    op(3, 1, 1, 1, 32'h0000_0002);
    repeat (3) @(negedge clk);
    chk(2, 1, 1, 32'h0000_0100, "R9");
    @(negedge clk);
    irq_line[2] = 1;
    req_valid = 1; req_write = 1; req_secure = 1; req_addr = {4'd3, 6'd1}; req_wdata = 32'h4;
    @(negedge clk); req_valid = 0;
    chk(2, 1, 1, 32'h0000_0104, "R9");
    @(negedge clk); irq_line = '0;
    // R10 trigger masking, ignored group/grade writes
    op(7, 1, 1, 0, 32'hFFFF_FFFF);
    chk(7, 1, 1, 32'hFFFF_00FF, "R10");
    chk(7, 1, 0, 32'hFFFF_0000, "R10");
    op(6, 1, 1, 0, 32'h0);
    chk(6, 1, 1, 32'hFFFF_0000, "R10");
    op(8, 2, 1, 0, 32'h0);
    chk(8, 2, 1, 32'hE4E4_E4E4, "R10");
    chk(12, 1, 1, 32'h0, "R12");
    // mixed random sequence against the model
    cur_req = "R1";
    lfsr = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      int w;
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = int'(lfsr[3:0]);
      d = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      if (w == 9) d[0] = 1'b0;
      @(negedge clk);
      irq_line = lfsr[27:20] == 8'h00 ? '0 : {lfsr[12:0], lfsr[31:13], lfsr[7:0], lfsr[31:24]};
      req_valid = lfsr[4]; req_write = lfsr[5]; req_secure = lfsr[6];
      req_addr = {4'(w), 6'(lfsr[9:7] % 3'd7)}; req_wdata = d;
    end
    @(negedge clk); req_valid = 0; irq_line = '0;
    repeat (3) @(negedge clk);
    // R11 security-disable
    chk(9, 0, 0, 32'h0, "R11");
    op(9, 0, 1, 0, 32'h1);
    chk(9, 0, 1, 32'h0, "R11");
    op(9, 0, 1, 1, 32'h1);
    chk(9, 0, 0, 32'h1, "R11");
    op(9, 0, 1, 1, 32'h0);
    chk(9, 0, 1, 32'h1, "R11");
    op(0, 1, 1, 0, 32'hFFFF_FFFF);
    chk(0, 1, 0, 32'hFFFF_FFFF, "R4");
    chk(8, 2, 1, 32'h0, "R10");
    op(6, 2, 1, 0, 32'h0000_00F0);
    chk(6, 2, 0, 32'h0000_00F0, "R4");
    repeat (2) @(negedge clk);
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule